// File: doc/BRIEF.md
# Configurable Microcontroller I/O Port

This block is a general-purpose I/O port of up to eight pins that an 8-bit microcontroller controls through four byte-wide registers. Each pin's direction and its output source are set separately. A direction register sets each pin as an output or an input. An external output-enable product-term input, which comes from a programmable logic array outside this block, can also make a pin drive. A mode register switches each pin between two sources. In I/O mode the pin drives from the data-out register. In address-out mode it drives from an address that is latched on a strobe.

The microcontroller writes the registers with a single-cycle write strobe. Reads are combinational from the register offset. A read of the pin offset returns the pad input levels after a two-flop synchronizer. The pad drivers receive a per-pin data value and an active-high tri-state enable. A parameter shrinks the port to fewer pins, for example a four-pin port. Unused upper register bits then read as zero. A second parameter removes the mode register on ports that have no address-out mode.

Top module: `cfg_io_port`

## Requirements
- R1: While reset is asserted, and after it is released, the data-out, direction and mode registers read 0x00 and every `pin_oe` bit is 0 when `pt_oe` is 0. Every pin is therefore an input in I/O mode.
- R2: Writing the direction register (offset 1) sets the direction bits. A bit of 1 makes the pin an output and a bit of 0 makes it an input. `pin_oe` takes the new value in the cycle after the write. Writing 0x07 gives `pin_oe` = 0x07: pins 0 to 2 drive and pins 3 to 7 are inputs.
- R3: For each pin, `pin_oe` is 1 when its direction bit is 1 or its `pt_oe` bit is 1. It is 0 only when both are 0. With `pt_oe` all 0, the direction register alone sets `pin_oe`.
- R4: A pin whose mode bit is 0 (I/O mode) drives its data-out register bit (offset 0) on `pin_out`.
- R5: A pin whose mode bit is 1 (address-out mode) drives bit i of the address latched from `bus_addr` on the last cycle in which `addr_stb` was high. A change of `bus_addr` without the strobe leaves `pin_out` unchanged.
- R6: The register offsets on `reg_addr` are: 0 data-out, 1 direction, 2 mode, 3 pin input. Offsets 0 to 2 read back the last value written. Offset 3 is read-only, and a write to it leaves all registers and outputs unchanged.
- R7: A read of offset 3 returns `pin_in` through a two-flop synchronizer. A pin change that is set up before clock edge k is first visible after edge k+1.
- R8: With PIN_COUNT below 8, register bits PIN_COUNT and above read as 0 and ignore writes.
- R9: With HAS_ADDR_OUT = 0, the mode register reads 0 and ignores writes, and every pin drives its data-out bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr`, combinational |
| bus_addr | input | REG_W | Address to latch for address-out mode |
| addr_stb | input | 1 | Address latch strobe |
| pt_oe | input | PIN_COUNT | External output-enable product terms, active high |
| pin_in | input | PIN_COUNT | Pad input levels |
| pin_out | output | PIN_COUNT | Pad output data |
| pin_oe | output | PIN_COUNT | Pad tri-state enable, active high |

## Verification
The direction logic is tried with the 0x07 pattern. It is then tried with a product term on a pin whose direction bit is 0, and with both sources cleared. This separates an OR merge from a register-only or a term-only enable. The output source is tried with 0xA5 as data and 0x3C as the address under the split mode 0x0F. Each pin then shows which source it uses, and a `bus_addr` change without the strobe shows whether the value was truly latched. A reference model runs random writes, strobes and pin changes on an 8-pin port with address-out mode and on a 4-pin port without it. This shows the masking of the upper bits, the removed mode register and the two-cycle readback delay.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;

  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_MODE = 2'd2,
    OFS_PINS = 2'd3
  } reg_ofs_e;

endpackage

// File: rtl/cfg_io_port_rst_sync.sv
module cfg_io_port_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/cfg_io_port_sync.sv
module cfg_io_port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      held_q <= '0;
    end else begin
      meta_q <= d;
      held_q <= meta_q;
    end
  end

  assign q = held_q;

endmodule

// File: rtl/cfg_io_port_regs.sv
module cfg_io_port_regs
  import cfg_io_port_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int PIN_COUNT    = 8,
  parameter bit HAS_ADDR_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_ofs_e             wr_ofs,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [REG_W-1:0]     addr_in,
  input  logic                 addr_stb,
  output logic [PIN_COUNT-1:0] data_q,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] mode_q,
  output logic [PIN_COUNT-1:0] alat_q
);

  logic [PIN_COUNT-1:0] data_d;
  logic [PIN_COUNT-1:0] dir_d;
  logic                 data_en;
  logic                 dir_en;

  always_comb begin
    data_en = wr_en && (wr_ofs == OFS_DATA);
    dir_en  = wr_en && (wr_ofs == OFS_DIR);
    data_d  = data_q;
    dir_d   = dir_q;
    if (data_en) data_d = wr_data[PIN_COUNT-1:0];
    if (dir_en)  dir_d  = wr_data[PIN_COUNT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  generate
    if (HAS_ADDR_OUT) begin : g_mode
      logic [PIN_COUNT-1:0] mode_d;
      logic [PIN_COUNT-1:0] alat_d;
      logic                 mode_en;

      always_comb begin
        mode_en = wr_en && (wr_ofs == OFS_MODE);
        mode_d  = mode_q;
        alat_d  = alat_q;
        if (mode_en)  mode_d = wr_data[PIN_COUNT-1:0];
        if (addr_stb) alat_d = addr_in[PIN_COUNT-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q <= '0;
          alat_q <= '0;
        end else begin
          mode_q <= mode_d;
          alat_q <= alat_d;
        end
      end
    end else begin : g_no_mode
      assign mode_q = '0;
      assign alat_q = '0;
    end
  endgenerate

endmodule

// File: rtl/cfg_io_port_pinmux.sv
module cfg_io_port_pinmux #(
  parameter int PIN_COUNT = 8
) (
  input  logic [PIN_COUNT-1:0] data_q,
  input  logic [PIN_COUNT-1:0] dir_q,
  input  logic [PIN_COUNT-1:0] mode_q,
  input  logic [PIN_COUNT-1:0] alat_q,
  input  logic [PIN_COUNT-1:0] pt_oe,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);

  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
      assign pin_out[i] = mode_q[i] ? alat_q[i] : data_q[i];
      assign pin_oe[i]  = dir_q[i] | pt_oe[i];
    end
  endgenerate

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfg_io_port_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int PIN_COUNT    = 8,
  parameter bit HAS_ADDR_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [REG_W-1:0]     bus_addr,
  input  logic                 addr_stb,
  input  logic [PIN_COUNT-1:0] pt_oe,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);

  logic                 rst_int_n;
  logic [PIN_COUNT-1:0] data_q;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] mode_q;
  logic [PIN_COUNT-1:0] alat_q;
  logic [PIN_COUNT-1:0] pins_sync;
  reg_ofs_e             ofs;

  assign ofs = reg_ofs_e'(reg_addr);

  cfg_io_port_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_int_n)
  );

  cfg_io_port_regs #(
    .REG_W        (REG_W),
    .PIN_COUNT    (PIN_COUNT),
    .HAS_ADDR_OUT (HAS_ADDR_OUT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr),
    .wr_ofs   (ofs),
    .wr_data  (reg_wdata),
    .addr_in  (bus_addr),
    .addr_stb (addr_stb),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .mode_q   (mode_q),
    .alat_q   (alat_q)
  );

  cfg_io_port_sync #(.W(PIN_COUNT)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  cfg_io_port_pinmux #(.PIN_COUNT(PIN_COUNT)) u_mux (
    .data_q  (data_q),
    .dir_q   (dir_q),
    .mode_q  (mode_q),
    .alat_q  (alat_q),
    .pt_oe   (pt_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (ofs)
      OFS_DATA: reg_rdata[PIN_COUNT-1:0] = data_q;
      OFS_DIR:  reg_rdata[PIN_COUNT-1:0] = dir_q;
      OFS_MODE: reg_rdata[PIN_COUNT-1:0] = mode_q;
      OFS_PINS: reg_rdata[PIN_COUNT-1:0] = pins_sync;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk #(
  parameter int REG_W        = 8,
  parameter int PIN_COUNT    = 8,
  parameter bit HAS_ADDR_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [1:0]           reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [REG_W-1:0]     reg_rdata,
  input logic [REG_W-1:0]     bus_addr,
  input logic                 addr_stb,
  input logic [PIN_COUNT-1:0] pt_oe,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [PIN_COUNT-1:0] data_q,
  input logic [PIN_COUNT-1:0] mode_q
);

  // R1: in reset with no product term, no pin drives
  p_reset_idle_r1: assert property (@(posedge clk)
    (!rst_n && pt_oe == '0) |-> pin_oe == '0);

  // R2: a direction write shows on pin_oe in the next cycle
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=>
      ((pin_oe & ~pt_oe) == ($past(reg_wdata[PIN_COUNT-1:0]) & ~pt_oe)));

  // R2: pin_oe only moves on a direction write or a product-term change
  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> (!$stable(pt_oe) || $stable(pin_oe)));

  // R3: an active product term always enables its pin
  p_pt_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_oe & ~pin_oe) == '0);

  // R4: pins in I/O mode follow the data-out register
  p_io_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ data_q) & ~mode_q) == '0);

  // R5: a strobe loads the address onto address-out pins
  p_addr_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && !reg_wr) |=>
      (((pin_out ^ $past(bus_addr[PIN_COUNT-1:0])) & mode_q) == '0));

  generate
    if (PIN_COUNT < REG_W) begin : g_narrow
      // R8: unimplemented bits read zero
      p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata >> PIN_COUNT) == '0);
    end
    if (!HAS_ADDR_OUT) begin : g_nomode
      // R9: without the mode register it reads zero
      p_mode_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd2 |-> reg_rdata == '0);
    end
  endgenerate

endmodule

bind cfg_io_port cfg_io_port_chk #(
  .REG_W        (REG_W),
  .PIN_COUNT    (PIN_COUNT),
  .HAS_ADDR_OUT (HAS_ADDR_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .bus_addr  (bus_addr),
  .addr_stb  (addr_stb),
  .pt_oe     (pt_oe),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .data_q    (data_q),
  .mode_q    (mode_q)
);

// File: tb/sim_cfg_io_port.sv
`timescale 1ns/1ps
module sim_cfg_io_port;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] bus_addr = 8'h00;
  logic       addr_stb = 1'b0;
  logic [7:0] pt_oe = 8'h00;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] rdata0, pout0, poe0;
  logic [7:0] rdata1;
  logic [3:0] pout1, poe1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cfg_io_port #(.REG_W(8), .PIN_COUNT(8), .HAS_ADDR_OUT(1'b1)) u0 (
    .clk(clk), .arst_n(arst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .bus_addr(bus_addr),
    .addr_stb(addr_stb), .pt_oe(pt_oe), .pin_in(pin_in),
    .pin_out(pout0), .pin_oe(poe0)
  );

  cfg_io_port #(.REG_W(8), .PIN_COUNT(4), .HAS_ADDR_OUT(1'b0)) u1 (
    .clk(clk), .arst_n(arst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .bus_addr(bus_addr),
    .addr_stb(addr_stb), .pt_oe(pt_oe[3:0]), .pin_in(pin_in[3:0]),
    .pin_out(pout1), .pin_oe(poe1)
  );

  // reference model: index 0 = wide port with mode, index 1 = 4-pin port without
  logic [7:0] m_dout [2];
  logic [7:0] m_dir  [2];
  logic [7:0] m_mode [2];
  logic [7:0] m_alat [2];
  logic [7:0] m_s1   [2];
  logic [7:0] m_s2   [2];
  logic [7:0] m_mask [2];
  bit         m_ctl  [2];

  initial begin
    m_mask[0] = 8'hFF; m_ctl[0] = 1'b1;
    m_mask[1] = 8'h0F; m_ctl[1] = 1'b0;
  end

  always @(posedge clk or negedge arst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!arst_n) begin
        m_dout[i] <= 8'h00; m_dir[i] <= 8'h00; m_mode[i] <= 8'h00;
        m_alat[i] <= 8'h00; m_s1[i]  <= 8'h00; m_s2[i]   <= 8'h00;
      end else begin
        m_s1[i] <= pin_in & m_mask[i];
        m_s2[i] <= m_s1[i];
        if (reg_wr && reg_addr == 2'd0) m_dout[i] <= reg_wdata & m_mask[i];
        if (reg_wr && reg_addr == 2'd1) m_dir[i]  <= reg_wdata & m_mask[i];
        if (reg_wr && reg_addr == 2'd2 && m_ctl[i]) m_mode[i] <= reg_wdata & m_mask[i];
        if (addr_stb && m_ctl[i]) m_alat[i] <= bus_addr & m_mask[i];
      end
    end
  end

  function automatic logic [7:0] exp_oe(int i);
    return (m_dir[i] | pt_oe) & m_mask[i];
  endfunction

  function automatic logic [7:0] exp_out(int i);
    return ((m_mode[i] & m_alat[i]) | (~m_mode[i] & m_dout[i])) & m_mask[i];
  endfunction

  function automatic logic [7:0] exp_rd(int i);
    case (reg_addr)
      2'd0:    return m_dout[i];
      2'd1:    return m_dir[i];
      2'd2:    return m_mode[i];
      default: return m_s2[i];
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    if (arst_n && !done) begin
      check("R3 model pin_oe u0", poe0, exp_oe(0));
      check("R4/R5 model pin_out u0", pout0, exp_out(0));
      check("R6 model rdata u0", rdata0, exp_rd(0));
      check("R8 model pin_oe u1", {4'h0, poe1}, exp_oe(1));
      check("R9 model pin_out u1", {4'h0, pout1}, exp_out(1));
      check("R8 model rdata u1", rdata1, exp_rd(1));
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] e0);
    reg_addr = a;
    #1;
    check(tag, rdata0, e0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    // R1: state while reset is held
    check("R1 oe in reset", poe0, 8'h00);
    rd_chk("R1 data in reset", 2'd0, 8'h00);
    arst_n = 1'b1;
    repeat (4) tick();
    rd_chk("R1 data after reset", 2'd0, 8'h00);
    rd_chk("R1 dir after reset", 2'd1, 8'h00);
    rd_chk("R1 mode after reset", 2'd2, 8'h00);
    check("R1 pin_oe after reset", poe0, 8'h00);

    // R2: direction example
    wr(2'd1, 8'h07);
    check("R2 pin_oe after 0x07", poe0, 8'h07);
    rd_chk("R6 dir readback", 2'd1, 8'h07);

    // R3: product term ORed in, and direction alone when term idle
    pt_oe = 8'h80; #1;
    check("R3 pt on input pin", poe0, 8'h87);
    pt_oe = 8'h01; #1;
    check("R3 pt on output pin", poe0, 8'h07);
    pt_oe = 8'h00;
    wr(2'd1, 8'h00);
    check("R3 both zero", poe0, 8'h00);

    // R4: I/O mode source
    wr(2'd0, 8'hA5);
    check("R4 pin_out data", pout0, 8'hA5);

    // R5: address-out source and latching
    bus_addr = 8'h3C; addr_stb = 1'b1;
    tick();
    addr_stb = 1'b0;
    wr(2'd2, 8'h0F);
    check("R5 mixed mode pin_out", pout0, 8'hAC);
    bus_addr = 8'hFF;
    tick();
    check("R5 no strobe keeps latch", pout0, 8'hAC);

    // R6: write to pin offset ignored
    wr(2'd3, 8'hFF);
    rd_chk("R6 pin offset read-only", 2'd3, 8'h00);
    rd_chk("R6 data unchanged", 2'd0, 8'hA5);
    check("R6 pin_out unchanged", pout0, 8'hAC);

    // R7: two-flop readback latency
    reg_addr = 2'd3;
    pin_in = 8'h5A;
    tick();
    rd_chk("R7 one edge old value", 2'd3, 8'h00);
    tick();
    rd_chk("R7 two edges new value", 2'd3, 8'h5A);

    // R8 / R9: narrow port without mode register
    wr(2'd1, 8'hFF);
    reg_addr = 2'd1; #1;
    check("R8 narrow dir upper zero", rdata1, 8'h0F);
    wr(2'd2, 8'hFF);
    reg_addr = 2'd2; #1;
    check("R9 narrow mode reads zero", rdata1, 8'h00);
    check("R9 narrow pins drive data", {4'h0, pout1}, 8'h05);

    // random traffic against the model
    for (int k = 0; k < 400; k++) begin
      reg_wr    = ($urandom_range(0, 2) == 0);
      reg_addr  = 2'($urandom_range(0, 3));
      reg_wdata = 8'($urandom);
      bus_addr  = 8'($urandom);
      addr_stb  = ($urandom_range(0, 3) == 0);
      pt_oe     = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom);
      pin_in    = 8'($urandom);
      tick();
    end
    reg_wr = 1'b0; addr_stb = 1'b0;
    tick();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule